// File: doc/BRIEF.md
# DC-Balanced Embedded-Clock Frame Serializer

This block turns a stream of parallel payload words into a single serial bit stream, one word per frame of payload-plus-four bits. It runs entirely on the fast bit clock and makes its own word cadence: a frame is loaded into a shift register once every frame length of bit clocks, and `wordTake` tells the data source, one cycle ahead, that the word on `wordIn` is captured at the coming edge. Around the payload each frame carries a fixed one bit and a fixed zero bit, which give the receiver a guaranteed rising edge at every frame boundary to recover timing from. It also carries a balance flag saying whether the payload went out inverted, and an even-parity bit that the receiver uses to check integrity.

A running disparity (ones minus zeros of all payload bits sent so far) picks, per frame, whether to invert the payload, so the line stays close to DC-free with no coding needed upstream. Releasing the active-low powerdown input starts a fixed training run of all-zero idle frames; only after it does `ready` rise and user words get taken. The output enable only gates the line: framing, disparity and training continue underneath, so taking it low and high again picks up exactly where the stream would have been.

Top module: `dcFrameSerializer`

## Requirements
- R1: Every frame is DATA_W+4 bit clocks long; its first serial bit (frame bit 0) is always 1 and its last (bit DATA_W+3) is always 0.
- R2: Frame bits 1 to DATA_W carry the transmitted payload, payload bit 0 first.
- R3: With word disparity = 2*ones - DATA_W of the captured word, the payload is inverted only when both that value and the running disparity are nonzero and of the same sign; frame bit DATA_W+1 is 1 exactly when the payload was inverted.
- R4: The running disparity starts at zero after reset and after powerdown, and after each frame load grows by the disparity of the payload bits actually sent.
- R5: Frame bit DATA_W+2 makes the count of ones over the sent payload, the inversion flag and itself even.
- R6: Frames follow each other with no gap; `wordTake` is high only in the last cycle of a frame (or of the powerup cycle) once `ready` is set, and `wordIn` is captured at the following rising edge.
- R7: `serValid` is high only when `outEnable` and `powerDownN` are high and framing has started; while `serValid` is low `serOut` is 0.
- R8: The first frame starts loading at the first rising edge with `powerDownN` high; INIT_FRAMES all-zero idle frames are sent first, `ready` rises at the edge that loads the last of them, and no `wordTake` happens before that.
- R9: While `powerDownN` is low, every rising edge clears `ready`, the frame position, the training count and the running disparity; `serValid` and `wordTake` are low.
- R10: `outEnable` has no effect on framing, word capture or disparity; frames sent after re-enabling match those of an uninterrupted stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerDownN | input | 1 | Active-low powerdown; high lets the block run |
| outEnable | input | 1 | Line enable; low idles the line only |
| wordIn | input | DATA_W | Payload word, captured when `wordTake` is high |
| wordTake | output | 1 | Word on `wordIn` is captured at the next rising edge |
| serOut | output | 1 | Serial frame bit |
| serValid | output | 1 | Line driven; low models a tri-stated output |
| ready | output | 1 | Training finished, user words accepted |

## Verification
The bench builds the block with its default values, a 24-bit payload and 64 training frames, so the whole training run is walked frame by frame and the exact edge where `ready` rises is pinned down. With a 24-bit word the idle pattern has a disparity of -24, so training alone makes the invert decision flip each frame and ends with the running disparity back at zero. The word table then reaches balanced words, which are never inverted, and single-bit extremes of both signs that drive the disparity near its bounds. An enable gap and a powerdown in mid-stream show that the disparity carries through the gap and is cleared by powerdown.

// File: rtl/dcFramePkg.sv
package dcFramePkg;

  // Strobes passed from the frame control to the datapath each bit clock.
  typedef struct packed {
    logic clear;     // powerdown: flush frame and disparity state
    logic load;      // load a freshly built frame at this edge
    logic takeUser;  // the frame being loaded carries the user word
  } ctrlStrobeT;

endpackage

// File: rtl/onesCounter.sv
module onesCounter #(
  parameter int DATA_W = 24,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] word,
  output logic [CNT_W-1:0]  ones
);

  // Ripple sum of the word bits; one count per payload bit.
  logic [CNT_W-1:0] partial [DATA_W+1];

  assign partial[0] = '0;

  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_sum
      assign partial[i+1] = partial[i] + CNT_W'(word[i]);
    end
  endgenerate

  assign ones = partial[DATA_W];

endmodule

// File: rtl/frameCtrl.sv
module frameCtrl
  import dcFramePkg::*;
#(
  parameter int FRAME_W     = 28,
  parameter int INIT_FRAMES = 64,
  localparam int SLOT_W     = $clog2(FRAME_W),
  localparam int INIT_W     = $clog2(INIT_FRAMES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerDownN,
  output ctrlStrobeT strobe,
  output logic       active,
  output logic       ready
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_W - 1);
  localparam logic [INIT_W-1:0] LAST_INIT = INIT_W'(INIT_FRAMES - 1);

  logic [SLOT_W-1:0] slotCnt;
  logic [INIT_W-1:0] initCnt;

  always_comb begin
    strobe.clear    = !powerDownN;
    strobe.load     = powerDownN && (!active || (slotCnt == LAST_SLOT));
    strobe.takeUser = strobe.load && ready;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
      initCnt <= '0;
      active  <= 1'b0;
      ready   <= 1'b0;
    end else if (strobe.clear) begin
      slotCnt <= '0;
      initCnt <= '0;
      active  <= 1'b0;
      ready   <= 1'b0;
    end else if (strobe.load) begin
      slotCnt <= '0;
      active  <= 1'b1;
      if (!ready) begin
        if (initCnt == LAST_INIT) begin
          ready <= 1'b1;
        end else begin
          initCnt <= initCnt + 1'b1;
        end
      end
    end else if (active) begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

endmodule

// File: rtl/frameData.sv
module frameData
  import dcFramePkg::*;
#(
  parameter int DATA_W   = 24,
  localparam int FRAME_W = DATA_W + 4,
  localparam int CNT_W   = $clog2(DATA_W + 1),
  localparam int DISP_W  = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [DATA_W-1:0] wordIn,
  output logic              serBit
);

  logic [DATA_W-1:0]        payload;
  logic [CNT_W-1:0]         ones;
  logic signed [DISP_W-1:0] wordDisp;
  logic signed [DISP_W-1:0] txDisp;
  logic signed [DISP_W-1:0] runDisp;
  logic                     invert;
  logic [DATA_W-1:0]        txPayload;
  logic                     parityBit;
  logic [FRAME_W-1:0]       frameNext;
  logic [FRAME_W-1:0]       shiftReg;

  // Idle frames carry an all-zero payload.
  assign payload = strobe.takeUser ? wordIn : '0;

  onesCounter #(.DATA_W(DATA_W)) u_ones (
    .word (payload),
    .ones (ones)
  );

  always_comb begin
    wordDisp  = $signed({1'b0, ones, 1'b0}) - $signed(DISP_W'(DATA_W));
    invert    = (wordDisp != '0) && (runDisp != '0) &&
                (wordDisp[DISP_W-1] == runDisp[DISP_W-1]);
    txPayload = invert ? ~payload : payload;
    txDisp    = invert ? -wordDisp : wordDisp;
    parityBit = ^{txPayload, invert};
    // Shifted out from bit 0: high marker, payload, flag, parity, low marker.
    frameNext = {1'b0, parityBit, invert, txPayload, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      runDisp  <= '0;
    end else if (strobe.clear) begin
      shiftReg <= '0;
      runDisp  <= '0;
    end else if (strobe.load) begin
      shiftReg <= frameNext;
      runDisp  <= runDisp + txDisp;
    end else begin
      shiftReg <= shiftReg >> 1;
    end
  end

  assign serBit = shiftReg[0];

endmodule

// File: rtl/dcFrameSerializer.sv
module dcFrameSerializer
  import dcFramePkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int INIT_FRAMES = 64,
  localparam int FRAME_W    = DATA_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerDownN,
  input  logic              outEnable,
  input  logic [DATA_W-1:0] wordIn,
  output logic              wordTake,
  output logic              serOut,
  output logic              serValid,
  output logic              ready
);

  ctrlStrobeT strobe;
  logic       active;
  logic       serBit;

  frameCtrl #(
    .FRAME_W     (FRAME_W),
    .INIT_FRAMES (INIT_FRAMES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerDownN (powerDownN),
    .strobe     (strobe),
    .active     (active),
    .ready      (ready)
  );

  frameData #(.DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wordIn (wordIn),
    .serBit (serBit)
  );

  assign wordTake = strobe.takeUser;
  assign serValid = active && outEnable && powerDownN;
  assign serOut   = serValid && serBit;

endmodule

// File: rtl/dcFrameSerializerChk.sv
module dcFrameSerializerChk #(
  parameter int FRAME_W = 28,
  localparam int GAP_W  = $clog2(FRAME_W) + 1
) (
  input logic clk,
  input logic rstN,
  input logic powerDownN,
  input logic outEnable,
  input logic wordTake,
  input logic serOut,
  input logic serValid,
  input logic ready
);

  logic [GAP_W-1:0] gapCnt;
  logic             seenTake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      seenTake <= 1'b0;
    end else if (!powerDownN) begin
      gapCnt   <= '0;
      seenTake <= 1'b0;
    end else if (wordTake) begin
      gapCnt   <= '0;
      seenTake <= 1'b1;
    end else if (gapCnt != {GAP_W{1'b1}}) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // R7
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    serValid |-> (outEnable && powerDownN));

  // R7
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    !serValid |-> !serOut);

  // R8
  take_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordTake |-> ready);

  // R9
  pd_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !powerDownN |=> !ready);

  // R1
  clock_high_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordTake |=> (!serValid || serOut));

  // R6
  frame_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordTake && seenTake) |-> (gapCnt == GAP_W'(FRAME_W - 1)));

endmodule

bind dcFrameSerializer dcFrameSerializerChk #(.FRAME_W(DATA_W + 4)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .powerDownN (powerDownN),
  .outEnable  (outEnable),
  .wordTake   (wordTake),
  .serOut     (serOut),
  .serValid   (serValid),
  .ready      (ready)
);

// File: tb/dcFrameSerializer_bench.sv
module dcFrameSerializer_bench;

  localparam int DATA_W      = 24;
  localparam int INIT_FRAMES = 64;
  localparam int FRAME_W     = DATA_W + 4;
  localparam int NVEC        = 8;

  localparam logic [DATA_W-1:0] VECS [NVEC] = '{
    24'h000000, 24'hFFFFFF, 24'h000FFF, 24'h000001,
    24'hFFFFFE, 24'hA5A5A5, 24'h123456, 24'h800000
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              powerDownN;
  logic              outEnable;
  logic [DATA_W-1:0] wordIn;
  logic              wordTake;
  logic              serOut;
  logic              serValid;
  logic              ready;

  int checks = 0;
  int fails  = 0;
  int rdModel = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dcFrameSerializer #(
    .DATA_W      (DATA_W),
    .INIT_FRAMES (INIT_FRAMES)
  ) u_dcFrameSerializer (
    .clk        (clk),
    .rstN       (rstN),
    .powerDownN (powerDownN),
    .outEnable  (outEnable),
    .wordIn     (wordIn),
    .wordTake   (wordTake),
    .serOut     (serOut),
    .serValid   (serValid),
    .ready      (ready)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected frame from the requirements; updates the model disparity.
  function automatic logic [FRAME_W-1:0] mkFrame(input logic [DATA_W-1:0] w,
                                                 input int rdIn, output int rdOut);
    int n = 0;
    int d;
    bit inv;
    logic [DATA_W-1:0] tx;
    logic [FRAME_W-1:0] f;
    for (int i = 0; i < DATA_W; i++) n += int'(w[i]);
    d   = 2 * n - DATA_W;
    inv = (d != 0) && (rdIn != 0) && ((d > 0) == (rdIn > 0));
    tx  = inv ? ~w : w;
    rdOut = rdIn + (inv ? -d : d);
    f[0] = 1'b1;
    for (int i = 0; i < DATA_W; i++) f[i+1] = tx[i];
    f[DATA_W+1] = inv;
    f[DATA_W+2] = (^tx) ^ inv;
    f[DATA_W+3] = 1'b0;
    return f;
  endfunction

  // Called at the falling edge just before a load edge.
  task automatic grabFrame(output logic [FRAME_W-1:0] f, output int takes,
                           output int valids, output logic rdy0);
    takes = 0;
    valids = 0;
    rdy0 = 1'b0;
    for (int i = 0; i < FRAME_W; i++) begin
      @(negedge clk);
      f[i] = serOut;
      if (i == 0) rdy0 = ready;
      takes  += int'(wordTake);
      valids += int'(serValid);
    end
  endtask

  initial begin
    logic [FRAME_W-1:0] got;
    logic [FRAME_W-1:0] exp;
    int takes;
    int valids;
    logic rdy0;

    rstN = 1'b0;
    powerDownN = 1'b0;
    outEnable = 1'b1;
    wordIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!ready && !serValid && !wordTake && !serOut, "R9 reset state",
          {28'd0, ready, serValid, wordTake, serOut}, 32'd0);

    // Powerup and training run (R8)
    powerDownN = 1'b1;
    rdModel = 0;
    for (int f = 0; f < INIT_FRAMES; f++) begin
      grabFrame(got, takes, valids, rdy0);
      exp = mkFrame('0, rdModel, rdModel);
      check(got == exp, "R8 idle frame content", 32'(got), 32'(exp));
      check(rdy0 == (f == INIT_FRAMES - 1), "R8 ready edge", 32'(rdy0),
            32'(f == INIT_FRAMES - 1));
      check(takes == ((f == INIT_FRAMES - 1) ? 1 : 0), "R8 no take in training",
            32'(takes), 32'((f == INIT_FRAMES - 1) ? 1 : 0));
      if (f == 0) begin
        // R1 marker bits, R2 zero payload, R3 no inversion at zero disparity
        check(got == 28'h0000001, "R1 R3 first idle frame", 32'(got), 32'h0000001);
        check(valids == FRAME_W, "R7 valid while running", 32'(valids), 32'(FRAME_W));
      end
      if (f == 1) begin
        // R3 inverted, R5 parity over 24 ones plus flag, R4 disparity -24 carried
        check(got == 28'h7FFFFFF, "R3 R4 R5 second idle frame", 32'(got), 32'h7FFFFFF);
      end
    end

    // Table of user words (R2 R3 R4 R5 R6)
    for (int j = 0; j < NVEC; j++) begin
      wordIn = VECS[j];
      check(wordTake == 1'b1, "R6 take before load", 32'(wordTake), 32'd1);
      grabFrame(got, takes, valids, rdy0);
      exp = mkFrame(VECS[j], rdModel, rdModel);
      check(got == exp, "R2 R3 R4 R5 user frame", 32'(got), 32'(exp));
      check(takes == 1, "R6 one take per frame", 32'(takes), 32'd1);
    end

    // Balanced word is never inverted (R3)
    wordIn = 24'h0F0F0F;
    grabFrame(got, takes, valids, rdy0);
    exp = mkFrame(24'h0F0F0F, rdModel, rdModel);
    check(got[DATA_W+1] == 1'b0, "R3 balanced not inverted", 32'(got[DATA_W+1]), 32'd0);
    check(got == exp, "R5 balanced frame", 32'(got), 32'(exp));

    // Enable gap (R7 R10)
    wordIn = 24'h00000F;
    outEnable = 1'b0;
    grabFrame(got, takes, valids, rdy0);
    void'(mkFrame(24'h00000F, rdModel, rdModel));
    check(valids == 0, "R7 disabled line not valid", 32'(valids), 32'd0);
    check(got == '0, "R7 disabled line low", 32'(got), 32'd0);
    check(takes == 1, "R10 take continues while disabled", 32'(takes), 32'd1);
    outEnable = 1'b1;
    wordIn = 24'h00003F;
    grabFrame(got, takes, valids, rdy0);
    exp = mkFrame(24'h00003F, rdModel, rdModel);
    check(got == exp, "R10 stream resumes", 32'(got), 32'(exp));
    check(valids == FRAME_W, "R7 valid after re-enable", 32'(valids), 32'(FRAME_W));

    // Powerdown in mid-stream (R9 R4 R8)
    powerDownN = 1'b0;
    @(negedge clk);
    check(!ready && !serValid && !wordTake, "R9 powerdown clears",
          {29'd0, ready, serValid, wordTake}, 32'd0);
    powerDownN = 1'b1;
    grabFrame(got, takes, valids, rdy0);
    check(got == 28'h0000001 && !rdy0, "R4 R8 restart idle frame",
          32'(got), 32'h0000001);
    grabFrame(got, takes, valids, rdy0);
    check(got == 28'h7FFFFFF, "R4 disparity reset by powerdown", 32'(got), 32'h7FFFFFF);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule